// File: doc/BRIEF.md
# Fixed-Point Long Divider

This block divides one unsigned fixed-point number by another over many clock cycles. Two parameters set the format: `M` integer bits and `N` fraction bits. The dividend and the quotient are each `2M+N` bits wide. The divisor is `M+N` bits wide. Every operand and result carries `N` fraction bits, so one quotient LSB is worth 2^-N.

A one-cycle `enable` captures both operands. A small state machine then measures how many significant bits the divisor has and seeds a partial remainder with that many leading bits of the dividend. Internally the dividend is extended with `N` zero bits below its LSB. The machine then produces one quotient bit per three-cycle step by trial subtraction, bringing down one more dividend bit each step. A difference of exactly zero counts as a successful subtraction.

When the work is finished, `done` pulses for one cycle, and quotient, residue and the zero-divisor flag are updated together. They then hold until the next result. Setting `SIGNED` to 1 makes the block accept two's-complement operands: it divides their magnitudes and negates the quotient when the signs differ.

Top module: `fxdiv_top`

## Requirements
- R1: Formats and quotient value. The dividend a is `2M+N` bits and the divisor b is `M+N` bits, both with `N` fraction bits. With `SIGNED`=0 and b≠0, `quotient` equals floor(a·2^N / b) modulo 2^(2M+N), with `N` fraction bits.
- R2: With b≠0, `residue` equals (a·2^N) mod b. It is therefore always below the divisor, and zero for an exact division.
- R3: With b=0, the result shows `div_zero`=1, `quotient`=0 and `residue`=0, and `done` is seen no more than 3 cycles after the enable edge.
- R4: `div_zero` is 0 for every result whose captured divisor is nonzero.
- R5: `done` is high for exactly one cycle per operation. For a nonzero divisor it arrives no more than 3·(2M+2N)+4 cycles after the enable edge.
- R6: `quotient`, `residue` and `div_zero` change only in the cycle where `done` is high, and hold their values until the next `done`.
- R7: `enable` is ignored while an operation is in progress: the operands captured at the start decide the result.
- R8: With `SIGNED`=1, both operands are two's complement. The quotient is the R1 value computed on the magnitudes, negated modulo 2^(2M+N) when the operand signs differ. The residue is the R2 value computed on the magnitudes.
- R9: After reset, `done`, `div_zero`, `quotient` and `residue` are all 0.
- R10: A trial difference of exactly zero counts as a 1 bit. Equal nonzero operands give a quotient of 2^N (1.0) and a residue of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Start; captures the operands when the block is idle |
| dividend | input | 2M+N | Dividend, N fraction bits |
| divisor | input | M+N | Divisor, N fraction bits |
| quotient | output | 2M+N | Quotient, N fraction bits |
| residue | output | M+N | Final partial remainder |
| done | output | 1 | One-cycle pulse when the results are updated |
| div_zero | output | 1 | The last operation had a zero divisor |

## Verification
The assertions check on every cycle that `done` lasts one cycle and that the outputs change only with it. They also check that a busy block keeps its captured divisor, that the residue stays below that divisor, that the zero flag appears only with a zero divisor and zeroed results, and that the busy time stays within the bound. The arithmetic itself can only be shown by the bench scenarios. These scenarios cover the exact quotient and residue for random and corner operands, the signed variant's sign handling and wrap-around, and a result that is unaffected by a second enable arriving mid-operation.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SIZE,
    S_SEED,
    S_SUB,
    S_DECIDE,
    S_SHIFT,
    S_FINISH
  } fxdiv_state_e;
endpackage

// File: rtl/fxdiv_core.sv
module fxdiv_core #(
  parameter int M = 4,
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 negate,
  input  logic [2*M+N-1:0]     dividend,
  input  logic [M+N-1:0]       divisor,
  output logic [2*M+N-1:0]     quotient,
  output logic [M+N-1:0]       residue,
  output logic                 done,
  output logic                 div_zero,
  output logic                 busy,
  output logic [M+N-1:0]       held_divisor
);
  import fxdiv_pkg::*;

  localparam int DW = 2*M + N;
  localparam int VW = M + N;
  localparam int EW = DW + N;
  localparam int RW = VW + 1;
  localparam int CW = $clog2(EW + 1);

  // significant width of a divisor: index of its top set bit plus one
  function automatic logic [CW-1:0] sig_width(input logic [VW-1:0] v);
    logic [CW-1:0] w;
    w = '0;
    for (int i = 0; i < VW; i++) begin
      if (v[i]) w = CW'(i + 1);
    end
    return w;
  endfunction

  // leading len bits of the extended dividend, right aligned
  function automatic logic [RW-1:0] seed_bits(input logic [EW-1:0] e,
                                              input logic [CW-1:0] len);
    logic [EW-1:0] s;
    s = e >> (EW - int'(len));
    return s[RW-1:0];
  endfunction

  // trial subtraction; top bit set means the divisor did not fit
  function automatic logic [RW:0] trial(input logic [RW-1:0] r,
                                        input logic [VW-1:0] d);
    return {1'b0, r} - {2'b00, d};
  endfunction

  fxdiv_state_e st_q;
  logic [EW-1:0] ext_q;
  logic [VW-1:0] dvs_q;
  logic [RW-1:0] rem_q;
  logic [RW:0]   diff_q;
  logic [DW-1:0] acc_q;
  logic [CW-1:0] len_q;
  logic [CW-1:0] left_q;
  logic          neg_q;
  logic          zero_q;

  logic [CW-1:0] pick;
  logic [EW-1:0] shifted;
  logic          next_bit;
  logic          fits;

  assign pick     = left_q - 1'b1;
  assign shifted  = ext_q >> pick;
  assign next_bit = shifted[0];
  assign fits     = ~diff_q[RW];

  assign busy         = (st_q != S_IDLE);
  assign held_divisor = dvs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      ext_q    <= '0;
      dvs_q    <= '0;
      rem_q    <= '0;
      diff_q   <= '0;
      acc_q    <= '0;
      len_q    <= '0;
      left_q   <= '0;
      neg_q    <= 1'b0;
      zero_q   <= 1'b0;
      quotient <= '0;
      residue  <= '0;
      done     <= 1'b0;
      div_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (start) begin
            ext_q <= {dividend, {N{1'b0}}};
            dvs_q <= divisor;
            neg_q <= negate;
            acc_q <= '0;
            st_q  <= S_SIZE;
          end
        end
        S_SIZE: begin
          zero_q <= (dvs_q == '0);
          len_q  <= sig_width(dvs_q);
          st_q   <= (dvs_q == '0) ? S_FINISH : S_SEED;
        end
        S_SEED: begin
          rem_q  <= seed_bits(ext_q, len_q);
          left_q <= CW'(EW) - len_q;
          st_q   <= S_SUB;
        end
        S_SUB: begin
          diff_q <= trial(rem_q, dvs_q);
          st_q   <= S_DECIDE;
        end
        S_DECIDE: begin
          if (fits) rem_q <= diff_q[RW-1:0];
          acc_q <= {acc_q[DW-2:0], fits};
          st_q  <= S_SHIFT;
        end
        S_SHIFT: begin
          if (left_q != '0) begin
            rem_q  <= {rem_q[RW-2:0], next_bit};
            left_q <= left_q - 1'b1;
            st_q   <= S_SUB;
          end else begin
            st_q <= S_FINISH;
          end
        end
        S_FINISH: begin
          done <= 1'b1;
          if (zero_q) begin
            quotient <= '0;
            residue  <= '0;
            div_zero <= 1'b1;
          end else begin
            quotient <= neg_q ? (~acc_q + 1'b1) : acc_q;
            residue  <= rem_q[VW-1:0];
            div_zero <= 1'b0;
          end
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fxdiv_top.sv
module fxdiv_top #(
  parameter int M      = 4,
  parameter int N      = 4,
  parameter int SIGNED = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [2*M+N-1:0]     dividend,
  input  logic [M+N-1:0]       divisor,
  output logic [2*M+N-1:0]     quotient,
  output logic [M+N-1:0]       residue,
  output logic                 done,
  output logic                 div_zero
);
  localparam int DW = 2*M + N;
  localparam int VW = M + N;

  function automatic logic [DW-1:0] mag_a(input logic [DW-1:0] v);
    return v[DW-1] ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [VW-1:0] mag_b(input logic [VW-1:0] v);
    return v[VW-1] ? (~v + 1'b1) : v;
  endfunction

  logic [DW-1:0] op_a;
  logic [VW-1:0] op_b;
  logic          flip;
  logic          core_busy;
  logic [VW-1:0] held_divisor;

  generate
    if (SIGNED != 0) begin : g_signed
      assign op_a = mag_a(dividend);
      assign op_b = mag_b(divisor);
      assign flip = dividend[DW-1] ^ divisor[VW-1];
    end else begin : g_unsigned
      assign op_a = dividend;
      assign op_b = divisor;
      assign flip = 1'b0;
    end
  endgenerate

  fxdiv_core #(.M(M), .N(N)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (enable),
    .negate       (flip),
    .dividend     (op_a),
    .divisor      (op_b),
    .quotient     (quotient),
    .residue      (residue),
    .done         (done),
    .div_zero     (div_zero),
    .busy         (core_busy),
    .held_divisor (held_divisor)
  );
endmodule

// File: rtl/fxdiv_checker.sv
module fxdiv_checker #(
  parameter int M = 4,
  parameter int N = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [2*M+N-1:0] quotient,
  input logic [M+N-1:0]   residue,
  input logic             done,
  input logic             div_zero,
  input logic             core_busy,
  input logic [M+N-1:0]   held_divisor
);
  localparam int EW    = 2*M + 2*N;
  localparam int LIMIT = 3*EW + 4;

  logic [15:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (!core_busy) busy_cnt <= '0;
    else if (busy_cnt != 16'hFFFF) busy_cnt <= busy_cnt + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy |-> (busy_cnt <= 16'(LIMIT))); // R5
  AST_HOLD_Q: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quotient) |-> done); // R6
  AST_HOLD_R: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(residue) |-> done); // R6
  AST_HOLD_Z: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_zero) |-> done); // R6
  AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (quotient == '0 && residue == '0)); // R3
  AST_ZERO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (held_divisor == '0)); // R4
  AST_RES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (residue < held_divisor)); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_busy && enable) |=> $stable(held_divisor)); // R7
endmodule

bind fxdiv_top fxdiv_checker #(.M(M), .N(N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .quotient     (quotient),
  .residue      (residue),
  .done         (done),
  .div_zero     (div_zero),
  .core_busy    (core_busy),
  .held_divisor (held_divisor)
);

// File: tb/fxdiv_top_bench.sv
module fxdiv_top_bench;
  localparam int M  = 4;
  localparam int N  = 4;
  localparam int DW = 2*M + N;
  localparam int VW = M + N;
  localparam int EW = DW + N;
  localparam longint QMASK = (64'd1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [DW-1:0] dividend = '0;
  logic [VW-1:0] divisor = '0;
  logic [DW-1:0] q_u, q_s;
  logic [VW-1:0] r_u, r_s;
  logic d_u, d_s, z_u, z_s;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fxdiv_top #(.M(M), .N(N), .SIGNED(0)) u_fxdiv_top (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dividend(dividend),
    .divisor(divisor), .quotient(q_u), .residue(r_u), .done(d_u), .div_zero(z_u));

  fxdiv_top #(.M(M), .N(N), .SIGNED(1)) u_fxdiv_top_sgn (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dividend(dividend),
    .divisor(divisor), .quotient(q_s), .residue(r_s), .done(d_s), .div_zero(z_s));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected quotient restated as a scaled integer quotient
  function automatic longint ref_q(input longint a, input longint b, input bit neg);
    longint q;
    q = ((a * (64'd1 << N)) / b) & QMASK;
    if (neg) q = (-q) & QMASK;
    return q;
  endfunction

  function automatic longint ref_r(input longint a, input longint b);
    return (a * (64'd1 << N)) % b;
  endfunction

  function automatic longint smag(input longint v, input int w);
    longint s;
    s = v;
    if (v[w-1]) s = (64'd1 << w) - v;
    return s;
  endfunction

  task automatic run_op(input logic [DW-1:0] a, input logic [VW-1:0] b,
                        input bit interfere, input bit hold_check);
    int cyc;
    bit gu, gs;
    logic [DW-1:0] cqu, cqs;
    logic [VW-1:0] cru, crs;
    bit czu, czs;
    int lu;
    longint ma, mb;
    bit neg;
    gu = 0; gs = 0; cyc = 0; lu = 0;
    cqu = '0; cqs = '0; cru = '0; crs = '0; czu = 0; czs = 0;
    @(negedge clk);
    dividend = a; divisor = b; enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    while (!(gu && gs) && cyc < 1000) begin
      cyc++;
      if (interfere && cyc == 3) begin
        enable = 1'b1; dividend = ~a; divisor = ~b;
      end
      if (interfere && cyc == 5) enable = 1'b0;
      if (d_u && !gu) begin gu = 1; cqu = q_u; cru = r_u; czu = z_u; lu = cyc; end
      if (d_s && !gs) begin gs = 1; cqs = q_s; crs = r_s; czs = z_s; end
      if (!(gu && gs)) @(negedge clk);
    end
    enable = 1'b0;
    if (!(gu && gs)) begin
      check(0, "R5 done never seen", cyc, 0);
      return;
    end
    if (b == '0) begin
      check(czu == 1'b1, "R3 zero flag", czu, 1);
      check(cqu == '0 && cru == '0, "R3 zero results", cqu, 0);
      check(lu <= 3, "R3 zero latency", lu, 3);
      check(czs == 1'b1 && cqs == '0, "R3 signed zero", cqs, 0);
    end else begin
      check(cqu == DW'(ref_q(a, b, 0)), "R1 quotient", cqu, ref_q(a, b, 0));
      check(cru == VW'(ref_r(a, b)), "R2 residue", cru, ref_r(a, b));
      check(czu == 1'b0, "R4 flag clear", czu, 0);
      check(lu <= 3*EW + 4, "R5 latency", lu, 3*EW + 4);
      ma  = smag(longint'(a), DW);
      mb  = smag(longint'(b), VW);
      neg = a[DW-1] ^ b[VW-1];
      check(cqs == DW'(ref_q(ma, mb, neg)), "R8 signed quotient", cqs, ref_q(ma, mb, neg));
      check(crs == VW'(ref_r(ma, mb)), "R8 signed residue", crs, ref_r(ma, mb));
      check(czs == 1'b0, "R4 signed flag clear", czs, 0);
    end
    if (hold_check) begin
      repeat (4) @(negedge clk);
      check(q_u == cqu && r_u == cru && z_u == czu, "R6 outputs hold", q_u, cqu);
      check(d_u == 1'b0, "R5 done single cycle", d_u, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(d_u == 0 && z_u == 0 && q_u == '0 && r_u == '0, "R9 reset outputs", q_u, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(d_u == 0 && q_u == '0, "R9 after release", d_u, 0);

    // directed corners
    run_op(DW'(12'h010), VW'(8'h10), 0, 1);   // R10 equal operands -> 1.0
    check(q_u == DW'(1 << N) && r_u == '0, "R10 equal operands", q_u, 1 << N);
    run_op(DW'(12'h0AB), '0, 0, 1);           // R3 zero divisor
    run_op(DW'(12'h000), VW'(8'h01), 0, 0);
    run_op('1, VW'(8'h01), 0, 0);             // R1 wrap on overflow
    run_op('1, '1, 0, 0);
    run_op(DW'(12'h123), VW'(8'h80), 0, 0);
    run_op(DW'(12'h800), VW'(8'h81), 0, 1);   // R8 most negative / negative
    run_op(DW'(12'hF00), VW'(8'h30), 0, 0);
    run_op(DW'(12'h3C0), VW'(8'h07), 1, 1);   // R7 mid-operation enable
    run_op(DW'(12'h777), VW'(8'h05), 1, 0);   // R7

    for (int i = 0; i < 200; i++) begin
      logic [DW-1:0] ra;
      logic [VW-1:0] rb;
      ra = DW'($urandom);
      rb = VW'($urandom);
      if (i % 3 == 0) rb = VW'(rb >> ($urandom % VW));
      if (i % 17 == 0) rb = '0;
      run_op(ra, rb, (i % 11 == 0), (i % 7 == 0));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule